// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block commits the architectural side effects of taking a trap in a single clock edge. A trap event arrives as an exception code or an interrupt number, with a flag telling which, plus the faulting address and the PC of the trapping instruction. The unit forms the cause word and rewrites environment calls to match the current privilege. It then consults the exception or the interrupt delegation mask to decide whether supervisor or machine mode takes the trap.

The result is written into registered outputs: the next PC, the cause, exception PC and trap value of the chosen mode, the updated status word and the new privilege level. The current privilege and status word come in from the surrounding hart state. The registered outputs feed back into that state once the trap has been taken. Return from trap, vectored dispatch and software register access sit outside this unit.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, the privilege output is machine (encoding 3, with user 0, supervisor 1, hypervisor 2). The status word, next PC and all six cause/EPC/trap-value outputs are zero.
- R2: For an interrupt, the written cause has bit XLEN-1 set and holds the interrupt number in its low bits, with all other bits zero. For an exception, bit XLEN-1 is clear.
- R3: An exception with code 8 is rewritten to 8 plus the current privilege encoding, giving 8, 9, 10 or 11. Other codes pass through unchanged.
- R4: The delegation bit is read from the exception mask for exceptions and from the interrupt mask for interrupts. The bit index is the cause with the interrupt flag removed, after any rewrite under R3.
- R5: The trap goes to supervisor only when the current privilege is user or supervisor and the selected delegation bit is 1. Otherwise it goes to machine.
- R6: On supervisor entry, next PC equals the supervisor vector base unaltered, and scause/sepc are written. Status bit 5 takes old bit 1, bit 8 takes bit 0 of the old privilege, bit 1 clears, and the privilege becomes 1.
- R7: On machine entry, next PC equals the machine vector base unaltered, and mcause/mepc are written. Status bit 7 takes old bit 3, bits 12:11 take the old privilege, bit 3 clears, and the privilege becomes 3.
- R8: The chosen mode's trap value receives the fault address only for exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It is written as zero for every other exception and for all interrupts.
- R9: The cause, EPC and trap value of the mode not chosen keep their values. Status bits not named for the chosen mode pass through from the status input. With the valid strobe low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | Commit a trap on this clock edge |
| trap_irq_i | input | 1 | 1: event is an interrupt, 0: an exception |
| trap_code_i | input | CODE_W | Exception code or interrupt number |
| trap_addr_i | input | XLEN | Faulting address |
| pc_i | input | XLEN | PC of the trapping instruction |
| priv_i | input | 2 | Current privilege level |
| status_i | input | XLEN | Current status word |
| edeleg_i | input | XLEN | Exception delegation mask |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| svec_i | input | XLEN | Supervisor trap vector base |
| mvec_i | input | XLEN | Machine trap vector base |
| npc_o | output | XLEN | Next PC after the trap |
| priv_o | output | 2 | Privilege level after the trap |
| status_o | output | XLEN | Status word after the trap |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |

## Verification
All decode logic is combinational and ends in one register stage, so every output is due on the first rising edge at which trap_valid_i is high. The bench drives each event on a falling edge and lets exactly one rising edge pass. It drops the strobe and compares all nine outputs on the next falling edge against a model it keeps from the requirements. The hold cases then let several edges pass with the strobe low and stray inputs changing, and the same comparison must still hold.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  // status word bit positions
  localparam int unsigned ST_SIE  = 1;
  localparam int unsigned ST_MIE  = 3;
  localparam int unsigned ST_SPIE = 5;
  localparam int unsigned ST_MPIE = 7;
  localparam int unsigned ST_SPP  = 8;
  localparam int unsigned ST_MPP  = 11;

  localparam int unsigned ECALL_BASE = 8;

  // exception codes that capture the fault address
  localparam logic [15:0] ADDR_FAULT_MASK = 16'b1011_0000_1111_0011;

endpackage

// File: rtl/trap_cause_gen.sv
module trap_cause_gen
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned CODE_W = $clog2(XLEN)
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  priv_e             priv_i,
  output logic [CODE_W-1:0] idx_o,
  output logic [XLEN-1:0]   cause_o
);

  localparam logic [CODE_W-1:0] ECALL_CODE = CODE_W'(ECALL_BASE);

  logic is_ecall;
  logic [CODE_W-1:0] priv_ext;

  assign is_ecall = !irq_i && (code_i == ECALL_CODE);
  assign priv_ext = {{(CODE_W-2){1'b0}}, priv_i};

  always_comb begin
    idx_o = is_ecall ? (ECALL_CODE + priv_ext) : code_i;
    cause_o = '0;
    cause_o[CODE_W-1:0] = idx_o;
    cause_o[XLEN-1] = irq_i;
  end

endmodule

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned CODE_W = $clog2(XLEN)
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] idx_i,
  input  priv_e             priv_i,
  input  logic [XLEN-1:0]   edeleg_i,
  input  logic [XLEN-1:0]   ideleg_i,
  output logic              to_s_o
);

  logic [XLEN-1:0] mask;
  logic            bit_set;
  logic            low_priv;

  assign mask     = irq_i ? ideleg_i : edeleg_i;
  assign bit_set  = mask[idx_i];
  assign low_priv = (priv_i == PRIV_U) || (priv_i == PRIV_S);
  assign to_s_o   = low_priv && bit_set;

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] status_i,
  input  priv_e           priv_i,
  input  logic            to_s_i,
  output logic [XLEN-1:0] status_o
);

  always_comb begin
    status_o = status_i;
    if (to_s_i) begin
      status_o[ST_SPIE] = status_i[ST_SIE];
      status_o[ST_SPP]  = priv_i[0];
      status_o[ST_SIE]  = 1'b0;
    end else begin
      status_o[ST_MPIE]          = status_i[ST_MIE];
      status_o[ST_MPP +: 2]      = priv_i;
      status_o[ST_MIE]           = 1'b0;
    end
  end

endmodule

// File: rtl/trap_reg_bank.sv
module trap_reg_bank #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] tval_i,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] tval_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
      epc_o   <= '0;
      tval_o  <= '0;
    end else if (we_i) begin
      cause_o <= cause_i;
      epc_o   <= epc_i;
      tval_o  <= tval_i;
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned CODE_W = $clog2(XLEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_valid_i,
  input  logic              trap_irq_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic [XLEN-1:0]   trap_addr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [1:0]        priv_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   edeleg_i,
  input  logic [XLEN-1:0]   ideleg_i,
  input  logic [XLEN-1:0]   svec_i,
  input  logic [XLEN-1:0]   mvec_i,
  output logic [XLEN-1:0]   npc_o,
  output logic [1:0]        priv_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   stval_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mtval_o
);

  localparam int unsigned N_BANK = 2; // 0: supervisor, 1: machine

  priv_e             cur_priv;
  logic [CODE_W-1:0] idx;
  logic [XLEN-1:0]   cause;
  logic              to_s;
  logic              fault_hit;
  logic [XLEN-1:0]   tval;
  logic [XLEN-1:0]   status_nx;
  logic [N_BANK-1:0] bank_we;
  logic [N_BANK-1:0][XLEN-1:0] cause_w, epc_w, tval_w;

  assign cur_priv = priv_e'(priv_i);

  trap_cause_gen #(.XLEN(XLEN)) u_cause (
    .irq_i   (trap_irq_i),
    .code_i  (trap_code_i),
    .priv_i  (cur_priv),
    .idx_o   (idx),
    .cause_o (cause)
  );

  trap_deleg_sel #(.XLEN(XLEN)) u_deleg (
    .irq_i    (trap_irq_i),
    .idx_i    (idx),
    .priv_i   (cur_priv),
    .edeleg_i (edeleg_i),
    .ideleg_i (ideleg_i),
    .to_s_o   (to_s)
  );

  trap_status_upd #(.XLEN(XLEN)) u_status (
    .status_i (status_i),
    .priv_i   (cur_priv),
    .to_s_i   (to_s),
    .status_o (status_nx)
  );

  // address capture only for misaligned, access and page faults
  assign fault_hit = !trap_irq_i && (trap_code_i < CODE_W'(16))
                     && ADDR_FAULT_MASK[trap_code_i[3:0]];
  assign tval      = fault_hit ? trap_addr_i : '0;

  assign bank_we[0] = trap_valid_i && to_s;
  assign bank_we[1] = trap_valid_i && !to_s;

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    trap_reg_bank #(.XLEN(XLEN)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we[g]),
      .cause_i (cause),
      .epc_i   (pc_i),
      .tval_i  (tval),
      .cause_o (cause_w[g]),
      .epc_o   (epc_w[g]),
      .tval_o  (tval_w[g])
    );
  end

  assign scause_o = cause_w[0];
  assign sepc_o   = epc_w[0];
  assign stval_o  = tval_w[0];
  assign mcause_o = cause_w[1];
  assign mepc_o   = epc_w[1];
  assign mtval_o  = tval_w[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npc_o    <= '0;
      priv_o   <= PRIV_M;
      status_o <= '0;
    end else if (trap_valid_i) begin
      npc_o    <= to_s ? svec_i : mvec_i;
      priv_o   <= to_s ? PRIV_S : PRIV_M;
      status_o <= status_nx;
    end
  end

  assert_irq_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_irq_i |=>
      ((priv_o == 2'd3) ? mcause_o[XLEN-1] : scause_o[XLEN-1]));

  assert_m_stays_m_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && (priv_i == 2'd3) |=> (priv_o == 2'd3));

  assert_s_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (priv_o != 2'd1) ||
      (npc_o == $past(svec_i) && !status_o[ST_SIE] && sepc_o == $past(pc_i)));

  assert_m_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (priv_o != 2'd3) ||
      (npc_o == $past(mvec_i) && !status_o[ST_MIE] && mepc_o == $past(pc_i)));

  assert_irq_tval_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_irq_i |=>
      ((priv_o == 2'd3) ? (mtval_o == '0) : (stval_o == '0)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> $stable(priv_o) && $stable(npc_o) && $stable(status_o)
      && $stable(mcause_o) && $stable(scause_o));

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        irq = 1'b0;
  logic [4:0]  code = '0;
  logic [31:0] addr = '0, pc = '0, status = '0;
  logic [1:0]  priv = 2'd3;
  logic [31:0] edeleg = '0, ideleg = '0;
  logic [31:0] svec = 32'h0000_2000, mvec = 32'h0000_8000;
  logic [31:0] npc_o, status_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;
  logic [1:0]  priv_o;

  int checks = 0;
  int errors = 0;

  // model of the expected outputs
  logic [31:0] m_npc = '0, m_status = '0;
  logic [31:0] m_scause = '0, m_sepc = '0, m_stval = '0;
  logic [31:0] m_mcause = '0, m_mepc = '0, m_mtval = '0;
  logic [1:0]  m_priv = 2'd3;

  always #10 clk = ~clk;

  trap_entry_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(valid), .trap_irq_i(irq),
    .trap_code_i(code), .trap_addr_i(addr), .pc_i(pc), .priv_i(priv),
    .status_i(status), .edeleg_i(edeleg), .ideleg_i(ideleg),
    .svec_i(svec), .mvec_i(mvec), .npc_o(npc_o), .priv_o(priv_o),
    .status_o(status_o), .scause_o(scause_o), .sepc_o(sepc_o),
    .stval_o(stval_o), .mcause_o(mcause_o), .mepc_o(mepc_o), .mtval_o(mtval_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " npc"},    npc_o,         m_npc);
    chk({req, " priv"},   {30'd0, priv_o}, {30'd0, m_priv});
    chk({req, " status"}, status_o,      m_status);
    chk({req, " scause"}, scause_o,      m_scause);
    chk({req, " sepc"},   sepc_o,        m_sepc);
    chk({req, " stval"},  stval_o,       m_stval);
    chk({req, " mcause"}, mcause_o,      m_mcause);
    chk({req, " mepc"},   mepc_o,        m_mepc);
    chk({req, " mtval"},  mtval_o,       m_mtval);
  endtask

  // drives one event, updates the model from the requirements, checks everything
  task automatic run_trap(input string req, input logic t_irq, input logic [4:0] t_code,
                          input logic [31:0] t_addr, input logic [31:0] t_pc,
                          input logic [1:0] t_priv, input logic [31:0] t_status);
    logic [4:0]  fc;
    logic [31:0] cause, tv, st;
    logic        dbit, tos;
    fc    = (!t_irq && t_code == 5'd8) ? 5'd8 + {3'd0, t_priv} : t_code;   // R3
    cause = {t_irq, 26'd0, fc};                                             // R2
    dbit  = t_irq ? ideleg[fc] : edeleg[fc];                                // R4
    tos   = (t_priv <= 2'd1) && dbit;                                       // R5
    tv    = (!t_irq && (t_code inside {0,1,4,5,6,7,12,13,15})) ? t_addr : 32'd0; // R8
    st    = t_status;
    if (tos) begin
      st[5] = t_status[1]; st[8] = t_priv[0]; st[1] = 1'b0;
      m_npc = svec; m_priv = 2'd1;
      m_scause = cause; m_sepc = t_pc; m_stval = tv;
    end else begin
      st[7] = t_status[3]; st[12:11] = t_priv; st[3] = 1'b0;
      m_npc = mvec; m_priv = 2'd3;
      m_mcause = cause; m_mepc = t_pc; m_mtval = tv;
    end
    m_status = st;
    @(negedge clk);
    valid = 1'b1; irq = t_irq; code = t_code; addr = t_addr; pc = t_pc;
    priv = t_priv; status = t_status;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    chk_all(req);
  endtask

  task automatic test_reset();
    chk_all("R1 reset");
  endtask

  task automatic test_fault_deleg();
    edeleg = 32'h0000_2000; ideleg = '0;   // code 13 delegated
    run_trap("R6 load pf from U", 1'b0, 5'd13, 32'hDEAD_0040, 32'h0000_1004, 2'd0, 32'h0000_008A);
    run_trap("R5 load pf from M", 1'b0, 5'd13, 32'hBEEF_0080, 32'h0000_1008, 2'd3, 32'h0000_002A);
    run_trap("R7 load pf from H", 1'b0, 5'd13, 32'h1234_5678, 32'h0000_100C, 2'd2, 32'hF000_0008);
  endtask

  task automatic test_ecall();
    edeleg = 32'h0000_0100; ideleg = 32'h0000_0200; // only code 8 in exception mask
    run_trap("R3 ecall U", 1'b0, 5'd8, 32'h5555_5555, 32'h0000_2004, 2'd0, 32'h0000_0002);
    run_trap("R3 ecall S", 1'b0, 5'd8, 32'h5555_5555, 32'h0000_2008, 2'd1, 32'h0000_0002);
    run_trap("R3 ecall H", 1'b0, 5'd8, 32'h5555_5555, 32'h0000_200C, 2'd2, 32'h0000_0008);
    run_trap("R3 ecall M", 1'b0, 5'd8, 32'h5555_5555, 32'h0000_2010, 2'd3, 32'h0000_0008);
    edeleg = 32'h0000_0200;
    run_trap("R4 ecall S deleg", 1'b0, 5'd8, 32'h5555_5555, 32'h0000_2014, 2'd1, 32'h0000_0002);
  endtask

  task automatic test_irq();
    edeleg = 32'h0000_0080; ideleg = 32'h0000_0020;
    run_trap("R2 irq5 deleg", 1'b1, 5'd5, 32'hAAAA_0000, 32'h0000_3000, 2'd1, 32'h0000_0002);
    run_trap("R4 irq7 edeleg only", 1'b1, 5'd7, 32'hAAAA_0004, 32'h0000_3004, 2'd0, 32'h0000_000A);
    edeleg = '0; ideleg = 32'h0000_0004;
    run_trap("R4 exc2 ideleg only", 1'b0, 5'd2, 32'hAAAA_0008, 32'h0000_3008, 2'd0, 32'h0000_0002);
    ideleg = 32'h8000_0000;
    run_trap("R2 irq31 deleg", 1'b1, 5'd31, 32'hAAAA_000C, 32'h0000_300C, 2'd0, 32'h0000_0000);
  endtask

  task automatic test_tval_sweep();
    edeleg = 32'h0000_FFFF; ideleg = '0;
    for (int c = 0; c < 16; c++) begin
      run_trap("R8 sweep S", 1'b0, 5'(c), 32'hC0DE_0000 + 32'(c), 32'h0000_4000 + 32'(c * 4),
               2'd0, 32'h0000_0002);
      run_trap("R8 sweep M", 1'b0, 5'(c), 32'hF00D_0000 + 32'(c), 32'h0000_5000 + 32'(c * 4),
               2'd3, 32'h0000_0008);
    end
  endtask

  task automatic test_hold();
    @(negedge clk);
    irq = 1'b1; code = 5'd3; addr = 32'h9999_9999; pc = 32'h7777_7777;
    priv = 2'd0; status = 32'hFFFF_FFFF; edeleg = '1; ideleg = '1;
    svec = 32'h0000_A000; mvec = 32'h0000_B000;
    repeat (3) @(negedge clk);
    chk_all("R9 hold");
    svec = 32'h0000_2000; mvec = 32'h0000_8000;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_fault_deleg();
    test_ecall();
    test_irq();
    test_hold();
    test_tval_sweep();
    test_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule